// File: doc/BRIEF.md
# Two-Weight Generalized Parallel Counter

This block adds up bits that sit in two adjacent binary columns and returns the weighted total as one 4-bit binary number. The output has a single bit in each of four consecutive columns. A parameter selects the input shape. In the balanced shape, five bits carry weight 1 and five bits carry weight 2. In the skewed shape, six bits carry weight 1 and four bits carry weight 2. Both shapes have ten input bits and the same 4-bit output.

A separate single-column counter is also provided. It reports how many of its N input bits are set, as a binary number of ceil(log2(N+1)) bits.

The block also holds a row of balanced-shape slices laid across a word. Each slice reads one column pair from five operands. The row returns two vectors whose sum equals the sum of the five operands. This makes the row a five-to-two compression stage for a multi-operand adder.

Top module: `gpc_top`

## Requirements
- R1: In the balanced shape (FORM = FORM_55), `wsum_o` equals popcount(`w1_i`) + 2·popcount(`w2_i`), where `w1_i` holds the five weight-1 bits and `w2_i` holds the five weight-2 bits.
- R2: In the skewed shape (FORM = FORM_46), `w1_i` is 6 bits wide and `w2_i` is 4 bits wide, and `wsum_o` equals popcount(`w1_i`) + 2·popcount(`w2_i`).
- R3: The 4-bit output spans enough weight to hold the largest input total: 15 for the balanced shape and 14 for the skewed shape. Elaboration rejects any shape whose largest total does not fit.
- R4: `col_cnt_o` is ceil(log2(COL_N+1)) bits wide and equals the number of set bits in `col_i`.
- R5: The row output `row_a_o + row_b_o`, taken at full precision, equals `ops_i[0] + ops_i[1] + ops_i[2] + ops_i[3] + ops_i[4]`.
- R6: The slice for column pair (2s, 2s+1) reads bit 2s of every operand at weight 1 and bit 2s+1 at weight 2. It places its 4-bit result at bit offset 2s. The result goes into `row_a_o` when s is even and into `row_b_o` when s is odd. Every bit not covered by a slice is 0.
- R7: When every input is zero, every output is zero.
- R8: When every input bit is one, `wsum_o` is 15 in the balanced shape and 14 in the skewed shape.
- R9: The least significant bit of `wsum_o` equals the parity of `w1_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| w1_i | input | 5 (balanced) / 6 (skewed) | Bits of weight 1 for the two-column counter |
| w2_i | input | 5 (balanced) / 4 (skewed) | Bits of weight 2 for the two-column counter |
| wsum_o | output | 4 | Weighted sum, one bit per column |
| col_i | input | COL_N | Inputs of the single-column counter |
| col_cnt_o | output | ceil(log2(COL_N+1)) | Count of set bits in col_i |
| ops_i | input | 5×WIDTH | Five operands for the row compressor |
| row_a_o | output | WIDTH+2 | Results of the even-numbered slices |
| row_b_o | output | WIDTH+2 | Results of the odd-numbered slices |

## Verification
The bench builds two instances that share WIDTH = 16 and COL_N = 10.

The first instance uses the balanced shape. Its 2^10 input combinations are run exhaustively, as are all 2^10 inputs of the ten-bit column counter.

The second instance uses the skewed shape, so the same exhaustive sweep also covers the six-plus-four split and its 14 ceiling.

A 16-bit row has eight slices, so both `row_a_o` and `row_b_o` get several overlapping placements. This makes it possible to check slice-by-slice offsets and the top two carry-out columns with directed operand patterns.

// File: rtl/gpc_pkg.sv
package gpc_pkg;

   typedef enum logic {
      FORM_55 = 1'b0,
      FORM_46 = 1'b1
   } gpc_form_e;

   localparam int unsigned SUM_W   = 4;
   localparam int unsigned ROW_OPS = 5;

   function automatic int unsigned n_low(gpc_form_e f);
      return (f == FORM_55) ? 5 : 6;
   endfunction

   function automatic int unsigned n_high(gpc_form_e f);
      return (f == FORM_55) ? 5 : 4;
   endfunction

   function automatic int unsigned max_weight(gpc_form_e f);
      return n_low(f) + 2 * n_high(f);
   endfunction

endpackage

// File: rtl/gpc_col_count.sv
module gpc_col_count #(
   parameter int unsigned N     = 10,
   localparam int unsigned CW   = (N < 2) ? 1 : $clog2(N + 1)
) (
   input  logic [N-1:0]  bits_i,
   output logic [CW-1:0] cnt_o
);

   if (N == 0) begin : g_bad_n
      $error("gpc_col_count: N must be at least 1");
   end

   if (N == 3) begin : g_full_adder
      // Three inputs: a plain full adder, sum then carry
      assign cnt_o[0] = bits_i[0] ^ bits_i[1] ^ bits_i[2];
      assign cnt_o[1] = (bits_i[0] & bits_i[1]) |
                        (bits_i[2] & (bits_i[0] ^ bits_i[1]));
   end else if (N == 2) begin : g_half_adder
      assign cnt_o[0] = bits_i[0] ^ bits_i[1];
      assign cnt_o[1] = bits_i[0] & bits_i[1];
   end else begin : g_accum
      always_comb begin
         logic [CW-1:0] acc;
         acc = '0;
         for (int k = 0; k < int'(N); k++) begin
            acc = acc + CW'(bits_i[k]);
         end
         cnt_o = acc;
      end
   end

   // R4: count never exceeds input count; lsb tracks parity
   always_comb begin
      p_cnt_bound_r4: assert (int'(cnt_o) <= int'(N))
         else $error("column count above N");
      p_cnt_parity_r4: assert (cnt_o[0] == ^bits_i)
         else $error("column count parity mismatch");
   end

endmodule

// File: rtl/gpc_two_col.sv
module gpc_two_col
   import gpc_pkg::*;
#(
   parameter gpc_form_e FORM = FORM_55,
   localparam int unsigned NL = n_low(FORM),
   localparam int unsigned NH = n_high(FORM)
) (
   input  logic [NL-1:0]    lo_i,
   input  logic [NH-1:0]    hi_i,
   output logic [SUM_W-1:0] sum_o
);

   localparam int unsigned LW   = $clog2(NL + 1);
   localparam int unsigned HW   = $clog2(NH + 1);
   localparam int unsigned MAXW = max_weight(FORM);

   // R3: output columns must cover the largest weighted total
   if (MAXW >= (1 << SUM_W)) begin : g_bad_cover
      $error("gpc_two_col: shape total exceeds output span");
   end

   logic [LW-1:0] lo_cnt;
   logic [HW-1:0] hi_cnt;

   gpc_col_count #(.N(NL)) u_lo (.bits_i(lo_i), .cnt_o(lo_cnt));
   gpc_col_count #(.N(NH)) u_hi (.bits_i(hi_i), .cnt_o(hi_cnt));

   always_comb begin
      sum_o = SUM_W'(lo_cnt) + (SUM_W'(hi_cnt) << 1);
   end

   always_comb begin
      p_range_r3: assert (int'(sum_o) <= int'(MAXW))
         else $error("weighted sum above shape maximum");
      p_lsb_parity_r9: assert (sum_o[0] == ^lo_i)
         else $error("sum lsb differs from low-column parity");
   end

endmodule

// File: rtl/gpc_row.sv
module gpc_row
   import gpc_pkg::*;
#(
   parameter int unsigned WIDTH = 16,
   localparam int unsigned OW   = WIDTH + 2
) (
   input  logic [ROW_OPS-1:0][WIDTH-1:0] ops_i,
   output logic [OW-1:0]                 a_o,
   output logic [OW-1:0]                 b_o
);

   localparam int unsigned NS = WIDTH / 2;
   localparam int unsigned XW = WIDTH + 3;

   if ((WIDTH % 2) != 0 || WIDTH < 2) begin : g_bad_width
      $error("gpc_row: WIDTH must be even and at least 2");
   end

   logic [NS-1:0][SUM_W-1:0] slice_res;

   for (genvar s = 0; s < int'(NS); s++) begin : g_slice
      logic [ROW_OPS-1:0] lo_bits;
      logic [ROW_OPS-1:0] hi_bits;
      for (genvar k = 0; k < int'(ROW_OPS); k++) begin : g_tap
         assign lo_bits[k] = ops_i[k][2*s];
         assign hi_bits[k] = ops_i[k][2*s+1];
      end
      gpc_two_col #(.FORM(FORM_55)) u_cnt (
         .lo_i (lo_bits),
         .hi_i (hi_bits),
         .sum_o(slice_res[s])
      );
   end

   // Even slices tile row A, odd slices tile row B
   always_comb begin
      a_o = '0;
      b_o = '0;
      for (int s = 0; s < int'(NS); s++) begin
         if ((s % 2) == 0) a_o[2*s +: SUM_W] = slice_res[s];
         else              b_o[2*s +: SUM_W] = slice_res[s];
      end
   end

   // R5: the two rows together carry exactly the five-operand total
   always_comb begin
      logic [XW-1:0] ref_sum;
      ref_sum = '0;
      for (int k = 0; k < int'(ROW_OPS); k++) ref_sum = ref_sum + XW'(ops_i[k]);
      p_row_total_r5: assert ((XW'(a_o) + XW'(b_o)) == ref_sum)
         else $error("row pair does not sum to operand total");
      p_row_b_low_r6: assert (b_o[1:0] == 2'b00)
         else $error("row B has bits below first odd slice");
   end

endmodule

// File: rtl/gpc_top.sv
module gpc_top
   import gpc_pkg::*;
#(
   parameter gpc_form_e   FORM  = FORM_55,
   parameter int unsigned WIDTH = 16,
   parameter int unsigned COL_N = 10
) (
   input  logic [n_low(FORM)-1:0]                  w1_i,
   input  logic [n_high(FORM)-1:0]                 w2_i,
   output logic [SUM_W-1:0]                        wsum_o,
   input  logic [COL_N-1:0]                        col_i,
   output logic [((COL_N < 2) ? 1 : $clog2(COL_N+1))-1:0] col_cnt_o,
   input  logic [ROW_OPS-1:0][WIDTH-1:0]           ops_i,
   output logic [WIDTH+1:0]                        row_a_o,
   output logic [WIDTH+1:0]                        row_b_o
);

   gpc_two_col #(.FORM(FORM)) u_pair (
      .lo_i (w1_i),
      .hi_i (w2_i),
      .sum_o(wsum_o)
   );

   gpc_col_count #(.N(COL_N)) u_col (
      .bits_i(col_i),
      .cnt_o (col_cnt_o)
   );

   gpc_row #(.WIDTH(WIDTH)) u_row (
      .ops_i(ops_i),
      .a_o  (row_a_o),
      .b_o  (row_b_o)
   );

   always_comb begin
      if (w1_i == '0 && w2_i == '0) begin
         p_zero_pair_r7: assert (wsum_o == '0)
            else $error("pair sum nonzero with zero inputs");
      end
      if (ops_i == '0) begin
         p_zero_row_r7: assert (row_a_o == '0 && row_b_o == '0)
            else $error("row nonzero with zero operands");
      end
      if (&w1_i && &w2_i) begin
         p_full_pair_r8: assert (int'(wsum_o) == int'(max_weight(FORM)))
            else $error("pair sum not at maximum with all ones");
      end
   end

endmodule

// File: tb/tb_gpc_top.sv
module tb_gpc_top;
   import gpc_pkg::*;

   localparam int W  = 16;
   localparam int CN = 10;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #10 clk = ~clk;

   int n_cmp = 0;
   int n_bad = 0;

   logic [4:0]          a_w1, a_w2;
   logic [3:0]          a_sum;
   logic [5:0]          b_w1;
   logic [3:0]          b_w2;
   logic [3:0]          b_sum;
   logic [CN-1:0]       col;
   logic [3:0]          a_cc, b_cc;
   logic [4:0][W-1:0]   ops;
   logic [W+1:0]        ra, rb, rb_a, rb_b;

   gpc_top #(.FORM(FORM_55), .WIDTH(W), .COL_N(CN)) dut (
      .w1_i(a_w1), .w2_i(a_w2), .wsum_o(a_sum),
      .col_i(col), .col_cnt_o(a_cc),
      .ops_i(ops), .row_a_o(ra), .row_b_o(rb)
   );

   gpc_top #(.FORM(FORM_46), .WIDTH(W), .COL_N(CN)) dut_b (
      .w1_i(b_w1), .w2_i(b_w2), .wsum_o(b_sum),
      .col_i(col), .col_cnt_o(b_cc),
      .ops_i(ops), .row_a_o(rb_a), .row_b_o(rb_b)
   );

   function automatic int ones(logic [31:0] v);
      int c = 0;
      for (int i = 0; i < 32; i++) c += int'(v[i]);
      return c;
   endfunction

   task automatic check(string req, longint act, longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic settle;
      @(negedge clk);
   endtask

   task automatic t_zero;
      @(posedge clk);
      a_w1 = '0; a_w2 = '0; b_w1 = '0; b_w2 = '0; col = '0; ops = '0;
      settle();
      check("R7 pair55", a_sum, 0);
      check("R7 pair46", b_sum, 0);
      check("R7 col", a_cc, 0);
      check("R7 rowA", ra, 0);
      check("R7 rowB", rb, 0);
   endtask

   task automatic t_sweep;
      for (int v = 0; v < 1024; v++) begin
         @(posedge clk);
         a_w1 = v[4:0]; a_w2 = v[9:5];
         b_w1 = v[5:0]; b_w2 = v[9:6];
         col  = v[9:0];
         settle();
         check("R1 balanced", a_sum, ones(v & 32'h1f) + 2 * ones((v >> 5) & 32'h1f));
         check("R2 skewed",   b_sum, ones(v & 32'h3f) + 2 * ones((v >> 6) & 32'hf));
         check("R4 column",   a_cc,  ones(v));
         check("R9 parity",   a_sum[0], ones(v & 32'h1f) % 2);
      end
   endtask

   task automatic t_full;
      @(posedge clk);
      a_w1 = '1; a_w2 = '1; b_w1 = '1; b_w2 = '1; col = '1;
      settle();
      check("R8 balanced max", a_sum, 15);
      check("R8 skewed max",   b_sum, 14);
      check("R3 balanced fits", a_sum, 15);
      check("R4 column all", a_cc, CN);
   endtask

   task automatic t_row_sum;
      logic [31:0] seed = 32'h1234_5678;
      for (int n = 0; n < 200; n++) begin
         longint tot = 0;
         @(posedge clk);
         for (int k = 0; k < 5; k++) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            ops[k] = (n < 4) ? {W{n[0]}} : seed[W-1:0];
            tot += longint'(ops[k]);
         end
         settle();
         check("R5 row total", longint'(ra) + longint'(rb), tot);
      end
   endtask

   task automatic t_row_place;
      for (int s = 0; s < W / 2; s++) begin
         for (int p = 0; p < 3; p++) begin
            int lo_n = (p == 0) ? 5 : (p == 1) ? 0 : 3;
            int hi_n = (p == 0) ? 5 : (p == 1) ? 4 : 1;
            longint exp_v = longint'(lo_n + 2 * hi_n) << (2 * s);
            @(posedge clk);
            ops = '0;
            for (int k = 0; k < 5; k++) begin
               if (k < lo_n) ops[k][2*s]   = 1'b1;
               if (k < hi_n) ops[k][2*s+1] = 1'b1;
            end
            settle();
            if (s % 2 == 0) begin
               check("R6 even slice in A", ra, exp_v);
               check("R6 other row B zero", rb, 0);
            end else begin
               check("R6 odd slice in B", rb, exp_v);
               check("R6 other row A zero", ra, 0);
            end
         end
      end
   endtask

   initial begin
      a_w1 = '0; a_w2 = '0; b_w1 = '0; b_w2 = '0; col = '0; ops = '0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      t_zero();
      t_sweep();
      t_full();
      t_row_sum();
      t_row_place();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule